// File: doc/BRIEF.md
# Selectable-width endian bus matcher

This block sits between a pair of 36-bit FIFOs and a single narrow-capable port. The port can run 36, 18 or 9 bits wide. In the outbound direction it takes each 36-bit word from the head of one FIFO and splits it into one, two or four transfers. In the inbound direction it gathers one, two or four transfers into a 36-bit word and hands that word to the other FIFO. Every side uses a valid/ready handshake. The outbound FIFO is read in show-ahead style: the head word is presented together with its valid flag, and the word is popped when ready is high in the same cycle.

The order in which the pieces of a word travel is set by an endianness input. Big-endian sends or receives the most significant piece first. Little-endian starts with the least significant piece. A narrow piece always sits on the low bits of the 36-bit port bus. The width and order inputs are captured on the first clock edge after reset is released. After that they stay fixed until the next reset. Reset also throws away any word that has been only partly gathered.

Top module: `bus_matcher`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `out_valid`, `in_ready`, `pop_ready` and `push_valid` are all low.
- R2: `cfg_size` is decoded as 2'b00 = 36 bits (one piece), 2'b01 = 18 bits (two pieces), 2'b10 = 9 bits (four pieces). The code 2'b11 behaves as 36 bits.
- R3: In 36-bit mode the outbound path is a pass-through. `out_data` equals `pop_data`, and `pop_ready` follows `out_ready` while `pop_valid` is high.
- R4: With `cfg_little` = 0, the outbound narrow pieces come most significant first. In 9-bit mode this means bits 35:27, then 26:18, then 17:9, then 8:0. In 18-bit mode it means 35:18, then 17:0. Each piece sits on `out_data` bits [w-1:0] and every bit above it is zero.
- R5: With `cfg_little` = 1, the outbound narrow pieces come least significant first: 8:0 first in 9-bit mode, and 17:0 first in 18-bit mode.
- R6: `pop_ready` is high only while the last piece of the current word is being accepted. Earlier pieces never pop the FIFO.
- R7: After the final inbound piece is accepted, `push_valid` goes high on the next cycle with the assembled word on `push_data`. The word is placed by the same endian rule as R4 and R5. `push_valid` and `push_data` hold until `push_ready` is high. `in_ready` stays low while they hold.
- R8: Inbound bits above the current piece width have no effect on the assembled word.
- R9: A change of `cfg_size` or `cfg_little` after the first cycle following reset has no effect until the next reset.
- R10: Reset discards a partly gathered inbound word. After reset, piece counting starts again from the first piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Port width select, captured after reset |
| cfg_little | input | 1 | 1 = least significant piece first |
| pop_data | input | 36 | Head word of the outbound FIFO |
| pop_valid | input | 1 | Outbound FIFO holds a word |
| pop_ready | output | 1 | Pops the outbound FIFO |
| out_data | output | 36 | Port-side outbound piece |
| out_valid | output | 1 | Outbound piece valid |
| out_ready | input | 1 | Port accepts outbound piece |
| in_data | input | 36 | Port-side inbound piece |
| in_valid | input | 1 | Inbound piece valid |
| in_ready | output | 1 | Block accepts inbound piece |
| push_data | output | 36 | Assembled word for the inbound FIFO |
| push_valid | output | 1 | Assembled word valid |
| push_ready | input | 1 | Inbound FIFO accepts the word |

## Verification
A wrong outbound piece counter shows up at once in two ways: the piece on `out_data` is the wrong one, and `pop_ready` rises on the wrong beat. The bench checks both on every beat of every word. A wrong inbound counter, or a wrong shift, shows up one cycle after the final piece, when `push_valid` rises early or late or `push_data` carries misplaced pieces. A configuration that is captured at the wrong time is caught on the first word after reset, because that word is split in the wrong order or to the wrong width.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10
  } size_e;

  localparam int unsigned LANES = 4;

  function automatic int unsigned pieces_of(size_e sz);
    case (sz)
      SZ_WORD: pieces_of = 2;
      SZ_BYTE: pieces_of = 4;
      default: pieces_of = 1;
    endcase
  endfunction

  // lowest lane index occupied by piece number idx
  function automatic int unsigned lane_of(size_e sz, logic little, int unsigned idx);
    int unsigned np;
    int unsigned slot;
    np   = pieces_of(sz);
    slot = little ? idx : (np - 1 - idx);
    lane_of = slot * (LANES / np);
  endfunction
endpackage

// File: rtl/bm_cfg.sv
module bm_cfg
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_size,
  input  logic       cfg_little,
  output size_e      size_q,
  output logic       little_q,
  output logic       loaded_q
);
  size_e size_d;
  logic  load_en;

  always_comb begin
    load_en = ~loaded_q;
    case (cfg_size)
      2'b01:   size_d = SZ_WORD;
      2'b10:   size_d = SZ_BYTE;
      default: size_d = SZ_LONG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= SZ_LONG;
      little_q <= 1'b0;
      loaded_q <= 1'b0;
    end else if (load_en) begin
      size_q   <= size_d;
      little_q <= cfg_little;
      loaded_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loaded,
  input  size_e             size,
  input  logic              little,
  input  logic [WORD_W-1:0] pop_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int unsigned LANE_W = WORD_W / LANES;
  localparam int unsigned IDX_W  = $clog2(LANES);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en, last;
  logic [WORD_W-1:0] mask;
  int unsigned       np, lane;

  always_comb begin
    np   = pieces_of(size);
    lane = lane_of(size, little, int'(idx_q));
    last = (int'(idx_q) == np - 1);
    mask = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (l < int'(LANES / np)) mask[l*LANE_W +: LANE_W] = '1;
    end
    out_valid = loaded & pop_valid;
    out_data  = (pop_data >> (lane * LANE_W)) & mask;
    pop_ready = loaded & out_ready & last;
    idx_en    = out_valid & out_ready;
    idx_d     = last ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end
endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loaded,
  input  size_e             size,
  input  logic              little,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] push_data,
  output logic              push_valid,
  input  logic              push_ready
);
  localparam int unsigned LANE_W = WORD_W / LANES;
  localparam int unsigned IDX_W  = $clog2(LANES);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              full_q, full_d;
  logic              take, last, reg_en;
  logic [WORD_W-1:0] mask;
  int unsigned       np, lane;

  always_comb begin
    np   = pieces_of(size);
    lane = lane_of(size, little, int'(idx_q));
    last = (int'(idx_q) == np - 1);
    mask = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (l < int'(LANES / np)) mask[l*LANE_W +: LANE_W] = '1;
    end
    in_ready   = loaded & ~full_q;
    push_valid = full_q;
    push_data  = acc_q;
    take       = in_valid & in_ready;
    acc_d      = acc_q;
    idx_d      = idx_q;
    full_d     = full_q;
    if (take) begin
      acc_d  = ((idx_q == '0) ? '0 : acc_q) | ((in_data & mask) << (lane * LANE_W));
      idx_d  = last ? '0 : idx_q + 1'b1;
      full_d = last;
    end else if (full_q && push_ready) begin
      full_d = 1'b0;
    end
    reg_en = take | (full_q & push_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      acc_q  <= '0;
      full_q <= 1'b0;
    end else if (reg_en) begin
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/bus_matcher.sv
module bus_matcher
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_little,
  input  logic [WORD_W-1:0] pop_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] push_data,
  output logic              push_valid,
  input  logic              push_ready
);
  size_e size_w;
  logic  little_w;
  logic  loaded_w;

  bm_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_little(cfg_little),
    .size_q(size_w), .little_q(little_w), .loaded_q(loaded_w)
  );

  bm_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .loaded(loaded_w), .size(size_w), .little(little_w),
    .pop_data(pop_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  bm_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .loaded(loaded_w), .size(size_w), .little(little_w),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .push_data(push_data), .push_valid(push_valid), .push_ready(push_ready)
  );
endmodule

// File: rtl/bus_matcher_chk.sv
module bus_matcher_chk
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loaded,
  input size_e             size,
  input logic              little,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              in_ready,
  input logic [WORD_W-1:0] push_data,
  input logic              push_valid,
  input logic              push_ready
);
  localparam int unsigned LANE_W = WORD_W / LANES;

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !out_valid && !in_ready && !pop_ready && !push_valid); // R1

  AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready && pop_valid |-> out_valid && out_ready); // R6

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && size == SZ_BYTE |-> out_data[WORD_W-1:LANE_W] == '0); // R4

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data)); // R7

  AST_NO_TAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !in_ready); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded && $stable(size) && $stable(little)); // R9
endmodule

bind bus_matcher bus_matcher_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loaded(loaded_w), .size(size_w), .little(little_w),
  .pop_valid(pop_valid), .pop_ready(pop_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
  .push_data(push_data), .push_valid(push_valid), .push_ready(push_ready)
);

// File: tb/bus_matcher_bench.sv
module bus_matcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   cfg_size;
  logic         cfg_little;
  logic [W-1:0] pop_data, out_data, in_data, push_data;
  logic         pop_valid, pop_ready, out_valid, out_ready;
  logic         in_valid, in_ready, push_valid, push_ready;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_matcher u_bus_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_little(cfg_little),
    .pop_data(pop_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .push_data(push_data), .push_valid(push_valid), .push_ready(push_ready)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int npieces(logic [1:0] sz);
    return (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [W-1:0] piece(logic [W-1:0] w, logic [1:0] sz, logic lit, int k);
    int n, pw, slot;
    logic [W-1:0] m;
    n    = npieces(sz);
    pw   = W / n;
    slot = lit ? k : n - 1 - k;
    m    = (n == 1) ? {W{1'b1}} : ((W'(1) << pw) - 1);
    return (w >> (slot * pw)) & m;
  endfunction

  task automatic do_reset(logic [1:0] sz, logic lit);
    @(negedge clk);
    rst_n = 1'b0; cfg_size = sz; cfg_little = lit;
    pop_valid = 1'b1; in_valid = 1'b1; out_ready = 1'b1; push_ready = 1'b0;
    #1;
    check("R1 reset out_valid", W'(out_valid), '0);
    check("R1 reset in_ready", W'(in_ready), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first cycle pop_ready", W'(pop_ready), '0);
    pop_valid = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic unpack_word(string req, logic [W-1:0] w, logic [1:0] sz, logic lit);
    int n;
    n = npieces(sz);
    for (int k = 0; k < n; k++) begin
      pop_data = w; pop_valid = 1'b1; out_ready = 1'b1;
      #1;
      check(req, out_data, piece(w, sz, lit, k));
      check("R6 pop only on last", W'(pop_ready), W'(k == n - 1));
      @(negedge clk);
    end
    pop_valid = 1'b0;
  endtask

  task automatic pack_word(string req, logic [W-1:0] w, logic [1:0] sz, logic lit, logic [W-1:0] junk);
    int n, pw;
    n  = npieces(sz);
    pw = W / n;
    push_ready = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_data  = (n == 1) ? piece(w, sz, lit, k) : (piece(w, sz, lit, k) | (junk << pw));
      in_valid = 1'b1;
      #1;
      check("R7 in_ready while gathering", W'(in_ready), W'(1));
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    check("R7 push_valid after last", W'(push_valid), W'(1));
    check(req, push_data, w);
    check("R7 in_ready low while held", W'(in_ready), '0);
    @(negedge clk);
    check("R7 push held", push_data, w);
    push_ready = 1'b1;
    @(negedge clk);
    push_ready = 1'b0;
    #1;
    check("R7 push cleared", W'(push_valid), '0);
  endtask

  task automatic t_long;
    do_reset(2'b00, 1'b0);
    unpack_word("R3 long pass-through", 36'h9_8765_4321, 2'b00, 1'b0);
    pack_word("R7 long pack", 36'hA_BCDE_F012, 2'b00, 1'b0, '0);
  endtask

  task automatic t_code3;
    do_reset(2'b11, 1'b1);
    unpack_word("R2 code 11 as long", 36'h1_2345_6789, 2'b00, 1'b0);
  endtask

  task automatic t_big;
    do_reset(2'b10, 1'b0);
    unpack_word("R4 byte big order", 36'h1_2345_6789, 2'b10, 1'b0);
    pack_word("R8 byte big pack junk ignored", 36'hF_0E1D_2C3B, 2'b10, 1'b0, {W{1'b1}});
    do_reset(2'b01, 1'b0);
    unpack_word("R4 word big order", 36'h3_00FF_A5A5, 2'b01, 1'b0);
    pack_word("R8 word big pack junk ignored", 36'h5_5AA5_0F0F, 2'b01, 1'b0, {W{1'b1}});
  endtask

  task automatic t_little;
    do_reset(2'b10, 1'b1);
    unpack_word("R5 byte little order", 36'h1_2345_6789, 2'b10, 1'b1);
    pack_word("R5 byte little pack", 36'h8_7654_3210, 2'b10, 1'b1, 36'h5);
    do_reset(2'b01, 1'b1);
    unpack_word("R5 word little order", 36'hC_3210_FEDC, 2'b01, 1'b1);
  endtask

  task automatic t_cfg_frozen;
    do_reset(2'b10, 1'b0);
    cfg_size = 2'b01; cfg_little = 1'b1;
    unpack_word("R9 cfg change ignored", 36'h7_7665_5443, 2'b10, 1'b0);
  endtask

  task automatic t_reset_partial;
    do_reset(2'b10, 1'b0);
    push_ready = 1'b0;
    in_data = 36'h0FF; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    do_reset(2'b10, 1'b0);
    pack_word("R10 partial word dropped", 36'h1_1223_3445, 2'b10, 1'b0, '0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_size = 2'b00; cfg_little = 1'b0;
    pop_data = '0; pop_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; in_valid = 1'b0; push_ready = 1'b0;
    t_long();
    t_code3();
    t_big();
    t_little();
    t_cfg_frozen();
    t_reset_partial();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule